// File: doc/BRIEF.md
# Synchronous Burst SRAM with Internal Burst Addressing

This block is a synthesizable, cycle-accurate single-port SRAM that samples all of its controls on the rising clock edge. An access starts when either of two address strobes is seen while the chip is selected. Once an access is open, the low two address bits can be stepped by an internal 2-bit counter, one step on each cycle with the advance input low. A controller therefore issues one address and receives or supplies up to four words. A fresh address may also be loaded on any cycle with no lost cycles.

Two static mode inputs pick the read path and the burst order. The read path is either flow-through, with data one edge after the address, or pipelined, with data one edge later. The burst order is either linear or interleaved. Writes go through per-byte strobes gated by a byte-write enable, or through a global write that stores the whole word. Output enable and sleep act on the output without waiting for a clock. Sleep also freezes all accesses and keeps the array contents.

Top module: `sync_burst_sram`

## Requirements
- R1: The chip counts as selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0 at the edge. A strobe seen while not selected starts nothing, writes nothing and ends any open access. One cycle later there is no read in progress.
- R2: A low `as_a_n` or `as_b_n` on a selected edge opens an access at the external address. A start by `as_a_n` is always a read, whatever the write controls are. A start by `as_b_n` alone obeys the write controls.
- R3: On a cycle inside an open access with no strobe, `adv_n`=0 steps the 2-bit burst counter. With `adv_n`=1, the previous address is accessed again. The address bits above the two low bits keep their values from the start.
- R4: With `lin_order`=1, the low bits of beat n are (start + n) mod 4.
- R5: With `lin_order`=0, the low bits of beat n are start XOR n. For example, a start of 1 gives 1,0,3,2.
- R6: With `flow_thru`=1, read data and `dq_en` appear after the edge that performs the read. With `flow_thru`=0, they appear one edge later.
- R7: With `gw_n`=1 and `bwe_n`=0, each `bstb_n[i]`=0 writes byte i, which is `wdata[8i+7:8i]`. The other bytes are kept. With `bwe_n`=1 and `gw_n`=1, nothing is written.
- R8: `gw_n`=0 writes all four bytes, whatever `bwe_n` and `bstb_n` are.
- R9: `oe_n`=1 forces `dq_en` low at once, without a clock. It does not disturb the data on `dq`.
- R10: `sleep`=1 forces `dq_en` low at once. While it is high, no edge reads or writes the array, and any open access ends. The array contents are kept.
- R11: With both mode inputs tied to 0, the block reads pipelined in interleaved order.
- R12: After reset, no access is open and `dq_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | External word address |
| wdata | input | DW | Write data |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| cs3_n | input | 1 | Chip select, active low |
| as_a_n | input | 1 | Address strobe that always starts a read |
| as_b_n | input | 1 | Address strobe that obeys the write controls |
| adv_n | input | 1 | Burst advance, active low |
| bstb_n | input | BYTES | Per-byte write strobes, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| gw_n | input | 1 | Global write, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous low-power request, active high |
| flow_thru | input | 1 | 1 selects flow-through reads, 0 selects pipelined reads |
| lin_order | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| dq | output | DW | Read data |
| dq_en | output | 1 | Output drivers enabled |

## Verification
Inputs change on the falling edge, so a read performed at rising edge k shows on `dq` at falling edge k+1 in flow-through mode and at falling edge k+2 in pipelined mode. The bench compares each burst beat at exactly that falling edge, using a latency of one or two, against a reference array. The effect of a write is checked through a later flow-through read, one falling edge after the read is issued. `oe_n` and `sleep` act without a clock, so their effect on `dq_en` is sampled 1 ns after the input changes, with no edge between.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int DEPTH = 256,
  parameter int AW    = $clog2(DEPTH),
  parameter int BYTES = 4,
  parameter int DW    = 8 * BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             cs3_n,
  input  logic             as_a_n,
  input  logic             as_b_n,
  input  logic             adv_n,
  input  logic [BYTES-1:0] bstb_n,
  input  logic             bwe_n,
  input  logic             gw_n,
  input  logic             oe_n,
  input  logic             sleep,
  input  logic             flow_thru,
  input  logic             lin_order,
  output logic [DW-1:0]    dq,
  output logic             dq_en
);
  logic [DW-1:0]    mem [DEPTH];
  logic [DW-1:0]    dout_q;
  logic [AW-1:0]    addr_q, cur_addr;
  logic [1:0]       cnt, cnt_nx, base_lo, lo_step;
  logic [BYTES-1:0] wmask;
  logic sel, strobe, start, step, access, wr_req, do_wr;
  logic active, rd_q, vld_q;

  assign sel     = !cs1_n && cs2 && !cs3_n;
  assign strobe  = !as_a_n || !as_b_n;
  assign start   = strobe && sel && !sleep;
  assign access  = start || (active && !strobe && !sleep);
  assign step    = access && !start && !adv_n;
  assign cnt_nx  = cnt + 2'd1;
  assign lo_step = lin_order ? base_lo + cnt_nx : base_lo ^ cnt_nx;

  always_comb begin
    if (start)     cur_addr = addr;
    else if (step) cur_addr = {addr_q[AW-1:2], lo_step};
    else           cur_addr = addr_q;
  end

  assign wr_req = !gw_n || (!bwe_n && !(&bstb_n));
  assign do_wr  = access && wr_req && !(start && !as_a_n);
  assign wmask  = !gw_n ? '1 : (bwe_n ? '0 : ~bstb_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      rd_q    <= 1'b0;
      vld_q   <= 1'b0;
      cnt     <= '0;
      base_lo <= '0;
      addr_q  <= '0;
      dout_q  <= '0;
    end else begin
      active <= access;
      rd_q   <= access && !do_wr;
      vld_q  <= rd_q;
      addr_q <= cur_addr;
      dout_q <= mem[addr_q];
      if (start) begin
        base_lo <= addr[1:0];
        cnt     <= '0;
      end else if (step) begin
        cnt <= cnt_nx;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int b = 0; b < BYTES; b++)
      if (do_wr && wmask[b]) mem[cur_addr][8*b +: 8] <= wdata[8*b +: 8];
  end

  assign dq    = flow_thru ? mem[addr_q] : dout_q;
  assign dq_en = !oe_n && !sleep && (flow_thru ? rd_q : vld_q);
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs1_n,
  input logic       cs2,
  input logic       cs3_n,
  input logic       as_a_n,
  input logic       as_b_n,
  input logic       adv_n,
  input logic       sleep,
  input logic       flow_thru,
  input logic       active,
  input logic       rd_q,
  input logic       vld_q,
  input logic [1:0] cnt,
  input logic       dq_en
);
  logic chip_on, no_strb;
  assign chip_on = !cs1_n && cs2 && !cs3_n;
  assign no_strb = as_a_n && as_b_n;

  AST_DESEL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!no_strb && !chip_on) |=> !rd_q); // R1
  AST_STROBE_A_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_a_n && chip_on && !sleep) |=> rd_q); // R2
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (active && no_strb && !adv_n && !sleep) |=> (cnt == 2'($past(cnt) + 2'd1))); // R3
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && no_strb && adv_n && !sleep) |=> $stable(cnt)); // R3
  AST_PIPE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_thru && rd_q) |=> vld_q); // R6
  AST_SLEEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (!rd_q && !active)); // R10
  AST_FLOW_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_thru && !rd_q) |-> !dq_en); // R6
endmodule

bind sync_burst_sram sync_burst_sram_chk u_chk (.*);

// File: tb/sim_sync_burst_sram.sv
module sim_sync_burst_sram;
  logic clk = 0, rst_n = 0;
  logic [7:0] addr;
  logic [31:0] wdata, dq;
  logic cs1_n, cs2, cs3_n, as_a_n, as_b_n, adv_n, bwe_n, gw_n, oe_n, sleep;
  logic flow_thru, lin_order, dq_en;
  logic [3:0] bstb_n;
  logic [31:0] ref_m [256];
  int total = 0, bad = 0;

  sync_burst_sram u0 (.*);

  always #5 clk = ~clk;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    as_a_n = 1; as_b_n = 1; adv_n = 1; cs1_n = 0; cs2 = 1; cs3_n = 0;
    gw_n = 1; bwe_n = 1; bstb_n = 4'hf; oe_n = 0; sleep = 0;
  endtask

  function automatic logic [7:0] bst(logic [7:0] s, int b, bit lin);
    logic [1:0] lo;
    lo = lin ? 2'(s[1:0] + 2'(b)) : (s[1:0] ^ 2'(b));
    return {s[7:2], lo};
  endfunction

  task automatic upd(logic [7:0] a, logic [31:0] d, logic g, logic bw, logic [3:0] bs);
    logic [3:0] m;
    m = !g ? 4'hf : (!bw ? ~bs : 4'h0);
    for (int k = 0; k < 4; k++) if (m[k]) ref_m[a][8*k +: 8] = d[8*k +: 8];
  endtask

  task automatic wr1(logic [7:0] a, logic [31:0] d, logic g, logic bw, logic [3:0] bs);
    @(negedge clk);
    idle(); as_b_n = 0; addr = a; wdata = d; gw_n = g; bwe_n = bw; bstb_n = bs;
    @(negedge clk);
    idle();
    upd(a, d, g, bw, bs);
  endtask

  task automatic rd1(string tag, logic [7:0] a);
    flow_thru = 1;
    @(negedge clk);
    idle(); as_b_n = 0; addr = a;
    @(negedge clk);
    idle();
    check(tag, {31'b0, dq_en}, 32'd1);
    check(tag, dq, ref_m[a]);
  endtask

  task automatic t_burst_read(logic [7:0] base, bit use_a, bit lin, bit flow);
    int lat, b;
    string tag;
    tag = lin ? "R4" : (flow ? "R5" : "R11");
    lin_order = lin; flow_thru = flow; lat = flow ? 1 : 2;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= 1) begin
        b = i - lat;
        if (b >= 0 && b < 4) begin
          check({tag, " R6"}, {31'b0, dq_en}, 32'd1);
          check({tag, use_a ? " R2" : ""}, dq, ref_m[bst(base, b, lin)]);
        end else if (flow && i == 5) check("R1", {31'b0, dq_en}, 32'd0);
      end
      idle();
      if (i == 0) begin
        addr = base;
        if (use_a) as_a_n = 0; else as_b_n = 0;
      end else if (i < 4) adv_n = 0;
      else begin
        as_b_n = 0; cs1_n = 1;
      end
    end
    @(negedge clk);
    idle();
  endtask

  task automatic t_hold();
    logic [7:0] seq [5] = '{8'd8, 8'd8, 8'd8, 8'd9, 8'd10};
    lin_order = 1; flow_thru = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= 1) check("R3", dq, ref_m[seq[i-1]]);
      idle();
      if (i == 0) begin addr = 8; as_b_n = 0; end
      else if (i >= 3) adv_n = 0;
    end
    @(negedge clk);
    idle();
  endtask

  task automatic t_byte_writes();
    wr1(40, 32'h11223344, 0, 1, 4'hf);
    wr1(40, 32'haabbccdd, 1, 0, 4'b1010);
    check("R7", ref_m[40], 32'h11bb33dd);
    rd1("R7", 40);
    wr1(40, 32'h55555555, 1, 1, 4'h0);
    rd1("R7", 40);
    wr1(41, 32'h0badf00d, 0, 1, 4'hf);
    rd1("R8", 41);
    wr1(41, 32'hcafe1234, 0, 0, 4'b1110);
    rd1("R8", 41);
  endtask

  task automatic t_burst_write();
    logic [31:0] d;
    lin_order = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      idle();
      d = 32'hd0d0_0000 + 32'(i);
      wdata = d; gw_n = 0;
      if (i == 0) begin addr = 50; as_b_n = 0; end
      else adv_n = 0;
      upd(bst(50, i, 1), d, 0, 1, 4'hf);
    end
    @(negedge clk);
    idle();
    for (int i = 0; i < 4; i++) rd1("R3", bst(50, i, 1));
  endtask

  task automatic t_strobe_a_write();
    @(negedge clk);
    idle(); as_a_n = 0; addr = 5; wdata = 32'hdeadbeef; gw_n = 0;
    @(negedge clk);
    idle();
    rd1("R2", 5);
  endtask

  task automatic t_desel_write();
    @(negedge clk);
    idle(); as_b_n = 0; cs2 = 0; addr = 6; wdata = 32'h66666666; gw_n = 0;
    @(negedge clk);
    idle(); as_b_n = 0; cs3_n = 1; addr = 6; wdata = 32'h77777777; gw_n = 0;
    @(negedge clk);
    idle();
    rd1("R1", 6);
  endtask

  task automatic t_oe();
    flow_thru = 1;
    @(negedge clk);
    idle(); as_b_n = 0; addr = 3;
    @(negedge clk);
    idle(); oe_n = 1;
    #1;
    check("R9", {31'b0, dq_en}, 32'd0);
    check("R9", dq, ref_m[3]);
    oe_n = 0;
    #1;
    check("R9", {31'b0, dq_en}, 32'd1);
  endtask

  task automatic t_sleep();
    flow_thru = 1;
    @(negedge clk);
    idle(); as_b_n = 0; addr = 7;
    @(negedge clk);
    idle(); sleep = 1;
    #1;
    check("R10", {31'b0, dq_en}, 32'd0);
    as_b_n = 0; addr = 7; wdata = 32'h99999999; gw_n = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10", {31'b0, dq_en}, 32'd0);
    end
    idle();
    rd1("R10", 7);
    rd1("R10", 12);
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end

  initial begin
    idle(); addr = 0; wdata = 0; flow_thru = 0; lin_order = 0;
    for (int a = 0; a < 256; a++) ref_m[a] = 'x;
    repeat (3) @(negedge clk);
    check("R12", {31'b0, dq_en}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    check("R12", {31'b0, dq_en}, 32'd0);
    for (int a = 0; a < 64; a++)
      wr1(8'(a), {8'(a), ~8'(a), 8'(a) ^ 8'h5a, 8'hc3}, 0, 1, 4'hf);
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 4; m++)
        t_burst_read(8'(16 + s), m[0], m[1], m[0] ^ m[1] ^ s[0]);
    t_burst_read(8'd33, 0, 0, 0);
    t_hold();
    t_byte_writes();
    t_burst_write();
    t_strobe_a_write();
    t_desel_write();
    t_oe();
    t_sleep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, bad);
    $finish;
  end
endmodule